// File: doc/BRIEF.md
# Translation Fault Diagnostic Capture

This block keeps the diagnostic state that software needs after an address translation fault. A data-side fault strobe comes with the faulting virtual address, the opcode and Ra fields of the faulting instruction, and three qualifiers: speculative, page-table-entry load and no-fault. When the fault is accepted, the block records three values. The first is the virtual address. The second is a status word that packs the two instruction fields. The third is a formatted page-table-entry address, built from the data page-table base and the virtual page number. An instruction-side fault strobe comes with the faulting PC and a speculative qualifier. When it is accepted, the block records the PC as a tag and a second formatted address, built from the instruction page-table base.

The block never locks its registers. A suppressed fault does not write them, so they keep whatever the last accepted fault left there. A later accepted fault overwrites them with no read needed in between. Software reads the five captured values through an address-decoded read port.

Top module: `xlat_fault_capture`

## Requirements
- R1: A data fault (`dFaultValid`=1) is captured only when `dFaultSpec`, `dFaultPteLoad` and `dFaultNoFault` are all 0. Captured values are readable from the clock edge that samples the strobe onward.
- R2: On data capture, the register at read address 0 takes `dFaultVaddr`.
- R3: On data capture, the register at read address 1 takes the status word. `dFaultOpcode` sits in bits [16:11], `dFaultRa` sits in bits [10:6], and every other bit is 0.
- R4: On data capture, the register at read address 2 takes `dPtBase | ((dFaultVaddr >> 13) << 3)`, using the base value present in the capture cycle.
- R5: An instruction fault (`iFaultValid`=1) with `iFaultSpec`=0 loads `iFaultPc` into the register at read address 3.
- R6: On instruction capture, the register at read address 4 takes `iPtBase | ((iFaultPc >> 13) << 3)`.
- R7: A suppressed fault, an idle cycle, or a change of either base register leaves all captured values unchanged. A later accepted fault overwrites them without any unlock step.
- R8: Reset (`rstN`=0) clears all five captured registers to zero.
- R9: `rdData` follows `rdAddr` combinationally. Read addresses 5, 6 and 7 return zero.
- R10: Data and instruction faults in the same cycle are qualified and captured independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dFaultValid | input | 1 | Data translation fault strobe |
| dFaultVaddr | input | ADDR_W | Faulting data virtual address |
| dFaultOpcode | input | 6 | Opcode field of the faulting instruction |
| dFaultRa | input | 5 | Ra field of the faulting instruction |
| dFaultSpec | input | 1 | Data access is speculative |
| dFaultPteLoad | input | 1 | Data access is a page-table-entry load |
| dFaultNoFault | input | 1 | Data access is marked no-fault |
| iFaultValid | input | 1 | Instruction translation fault strobe |
| iFaultPc | input | ADDR_W | Faulting instruction PC |
| iFaultSpec | input | 1 | Instruction fetch is speculative |
| dPtBase | input | ADDR_W | Data page-table base |
| iPtBase | input | ADDR_W | Instruction page-table base |
| rdAddr | input | 3 | Read register select |
| rdData | output | ADDR_W | Selected captured value |

## Verification
The hardest case to reach from the ports is a suppressed fault that arrives after registers already hold non-zero data, while the base registers have also moved. An untouched register then differs from both the reset value and a fresh formatting of the current inputs. The vector table therefore places accepted captures with distinct addresses and bases before each suppressed or speculative entry. It also changes the bases inside the suppressed entries, so a leak through any qualifier shows up as a changed read value. Mixed entries with both strobes high pair a suppressed side with an accepted side, which shows that the two qualifications do not interfere.

// File: rtl/xfc_pkg.sv
package xfc_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadData;
    logic loadInst;
  } xfcStrobe_t;

  // Read-port register selects
  typedef enum logic [2:0] {
    SEL_VA    = 3'd0,
    SEL_STAT  = 3'd1,
    SEL_DFORM = 3'd2,
    SEL_ITAG  = 3'd3,
    SEL_IFORM = 3'd4
  } xfcSel_e;

  localparam int OPC_W  = 6;
  localparam int RA_W   = 5;
  localparam int OPC_LSB = 11;
  localparam int RA_LSB  = 6;
  localparam int STAT_W  = OPC_LSB + OPC_W;

endpackage

// File: rtl/xfc_ctrl.sv
module xfc_ctrl
  import xfc_pkg::*;
(
  input  logic       dFaultValid,
  input  logic       dFaultSpec,
  input  logic       dFaultPteLoad,
  input  logic       dFaultNoFault,
  input  logic       iFaultValid,
  input  logic       iFaultSpec,
  output xfcStrobe_t strobe
);

  logic dBlocked;
  logic iBlocked;

  always_comb begin
    // Data side: speculative, table-walk and no-fault accesses skip capture
    dBlocked = dFaultSpec | dFaultPteLoad | dFaultNoFault;
    // Instruction side: only speculation blocks capture
    iBlocked = iFaultSpec;
    strobe.loadData = dFaultValid & ~dBlocked;
    strobe.loadInst = iFaultValid & ~iBlocked;
  end

endmodule

// File: rtl/xfc_fmt.sv
module xfc_fmt #(
  parameter int ADDR_W     = 64,
  parameter int PAGE_SHIFT = 13,
  parameter int PTE_SHIFT  = 3
) (
  input  logic [ADDR_W-1:0] ptBase,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] pteAddr
);

  localparam int VPN_W = ADDR_W - PAGE_SHIFT;

  logic [VPN_W-1:0]  vpn;
  logic [ADDR_W-1:0] vpnScaled;

  always_comb begin
    vpn       = addr[ADDR_W-1:PAGE_SHIFT];
    vpnScaled = ADDR_W'(vpn) << PTE_SHIFT;
    pteAddr   = ptBase | vpnScaled;
  end

endmodule

// File: rtl/xfc_datapath.sv
module xfc_datapath
  import xfc_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int PAGE_SHIFT = 13,
  parameter int PTE_SHIFT  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  xfcStrobe_t        strobe,
  input  logic [ADDR_W-1:0] dFaultVaddr,
  input  logic [OPC_W-1:0]  dFaultOpcode,
  input  logic [RA_W-1:0]   dFaultRa,
  input  logic [ADDR_W-1:0] iFaultPc,
  input  logic [ADDR_W-1:0] dPtBase,
  input  logic [ADDR_W-1:0] iPtBase,
  output logic [ADDR_W-1:0] capVa,
  output logic [ADDR_W-1:0] capStat,
  output logic [ADDR_W-1:0] capDForm,
  output logic [ADDR_W-1:0] capITag,
  output logic [ADDR_W-1:0] capIForm
);

  localparam int NUM_FMT = 2;

  logic [ADDR_W-1:0] fmtBase [NUM_FMT];
  logic [ADDR_W-1:0] fmtAddr [NUM_FMT];
  logic [ADDR_W-1:0] fmtOut  [NUM_FMT];
  logic [STAT_W-1:0] statNext;

  assign fmtBase[0] = dPtBase;
  assign fmtAddr[0] = dFaultVaddr;
  assign fmtBase[1] = iPtBase;
  assign fmtAddr[1] = iFaultPc;

  // One formatter per translation side
  for (genvar g = 0; g < NUM_FMT; g++) begin : gFmt
    xfc_fmt #(
      .ADDR_W    (ADDR_W),
      .PAGE_SHIFT(PAGE_SHIFT),
      .PTE_SHIFT (PTE_SHIFT)
    ) uFmt (
      .ptBase (fmtBase[g]),
      .addr   (fmtAddr[g]),
      .pteAddr(fmtOut[g])
    );
  end

  always_comb begin
    statNext = '0;
    statNext[OPC_LSB +: OPC_W] = dFaultOpcode;
    statNext[RA_LSB  +: RA_W]  = dFaultRa;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capVa    <= '0;
      capStat  <= '0;
      capDForm <= '0;
    end else if (strobe.loadData) begin
      capVa    <= dFaultVaddr;
      capStat  <= ADDR_W'(statNext);
      capDForm <= fmtOut[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capITag  <= '0;
      capIForm <= '0;
    end else if (strobe.loadInst) begin
      capITag  <= iFaultPc;
      capIForm <= fmtOut[1];
    end
  end

endmodule

// File: rtl/xfc_readmux.sv
module xfc_readmux
  import xfc_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic [2:0]        rdAddr,
  input  logic [ADDR_W-1:0] capVa,
  input  logic [ADDR_W-1:0] capStat,
  input  logic [ADDR_W-1:0] capDForm,
  input  logic [ADDR_W-1:0] capITag,
  input  logic [ADDR_W-1:0] capIForm,
  output logic [ADDR_W-1:0] rdData
);

  always_comb begin
    unique case (rdAddr)
      SEL_VA:    rdData = capVa;
      SEL_STAT:  rdData = capStat;
      SEL_DFORM: rdData = capDForm;
      SEL_ITAG:  rdData = capITag;
      SEL_IFORM: rdData = capIForm;
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/xlat_fault_capture.sv
module xlat_fault_capture
  import xfc_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int PAGE_SHIFT = 13,
  parameter int PTE_SHIFT  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dFaultValid,
  input  logic [ADDR_W-1:0] dFaultVaddr,
  input  logic [5:0]        dFaultOpcode,
  input  logic [4:0]        dFaultRa,
  input  logic              dFaultSpec,
  input  logic              dFaultPteLoad,
  input  logic              dFaultNoFault,
  input  logic              iFaultValid,
  input  logic [ADDR_W-1:0] iFaultPc,
  input  logic              iFaultSpec,
  input  logic [ADDR_W-1:0] dPtBase,
  input  logic [ADDR_W-1:0] iPtBase,
  input  logic [2:0]        rdAddr,
  output logic [ADDR_W-1:0] rdData
);

  xfcStrobe_t        strobe;
  logic [ADDR_W-1:0] capVa;
  logic [ADDR_W-1:0] capStat;
  logic [ADDR_W-1:0] capDForm;
  logic [ADDR_W-1:0] capITag;
  logic [ADDR_W-1:0] capIForm;

  xfc_ctrl uCtrl (
    .dFaultValid  (dFaultValid),
    .dFaultSpec   (dFaultSpec),
    .dFaultPteLoad(dFaultPteLoad),
    .dFaultNoFault(dFaultNoFault),
    .iFaultValid  (iFaultValid),
    .iFaultSpec   (iFaultSpec),
    .strobe       (strobe)
  );

  xfc_datapath #(
    .ADDR_W    (ADDR_W),
    .PAGE_SHIFT(PAGE_SHIFT),
    .PTE_SHIFT (PTE_SHIFT)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .dFaultVaddr (dFaultVaddr),
    .dFaultOpcode(dFaultOpcode),
    .dFaultRa    (dFaultRa),
    .iFaultPc    (iFaultPc),
    .dPtBase     (dPtBase),
    .iPtBase     (iPtBase),
    .capVa       (capVa),
    .capStat     (capStat),
    .capDForm    (capDForm),
    .capITag     (capITag),
    .capIForm    (capIForm)
  );

  xfc_readmux #(
    .ADDR_W(ADDR_W)
  ) uRd (
    .rdAddr  (rdAddr),
    .capVa   (capVa),
    .capStat (capStat),
    .capDForm(capDForm),
    .capITag (capITag),
    .capIForm(capIForm),
    .rdData  (rdData)
  );

endmodule

// File: rtl/xfc_checker.sv
module xfc_checker #(
  parameter int ADDR_W     = 64,
  parameter int PAGE_SHIFT = 13,
  parameter int PTE_SHIFT  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              dFaultValid,
  input logic [ADDR_W-1:0] dFaultVaddr,
  input logic [5:0]        dFaultOpcode,
  input logic [4:0]        dFaultRa,
  input logic              dFaultSpec,
  input logic              dFaultPteLoad,
  input logic              dFaultNoFault,
  input logic              iFaultValid,
  input logic [ADDR_W-1:0] iFaultPc,
  input logic              iFaultSpec,
  input logic [ADDR_W-1:0] dPtBase,
  input logic [ADDR_W-1:0] iPtBase,
  input logic [2:0]        rdAddr,
  input logic [ADDR_W-1:0] rdData,
  input logic [ADDR_W-1:0] capVa,
  input logic [ADDR_W-1:0] capStat,
  input logic [ADDR_W-1:0] capDForm,
  input logic [ADDR_W-1:0] capITag,
  input logic [ADDR_W-1:0] capIForm
);

  logic dTake;
  logic iTake;
  assign dTake = dFaultValid && !dFaultSpec && !dFaultPteLoad && !dFaultNoFault;
  assign iTake = iFaultValid && !iFaultSpec;

  AST_DATA_VA: assert property (@(posedge clk) disable iff (!rstN)
    dTake |=> capVa == $past(dFaultVaddr));                                   // R2
  AST_DATA_STAT: assert property (@(posedge clk) disable iff (!rstN)
    dTake |=> (capStat[16:11] == $past(dFaultOpcode)) && (capStat[10:6] == $past(dFaultRa))
              && (capStat[5:0] == 6'd0));                                     // R3
  AST_DATA_FORM: assert property (@(posedge clk) disable iff (!rstN)
    dTake |=> capDForm == ($past(dPtBase) | (($past(dFaultVaddr) >> PAGE_SHIFT) << PTE_SHIFT))); // R4
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !dTake |=> $stable(capVa) && $stable(capStat) && $stable(capDForm));      // R1
  AST_INST_TAG: assert property (@(posedge clk) disable iff (!rstN)
    iTake |=> capITag == $past(iFaultPc));                                    // R5
  AST_INST_FORM: assert property (@(posedge clk) disable iff (!rstN)
    iTake |=> capIForm == ($past(iPtBase) | (($past(iFaultPc) >> PAGE_SHIFT) << PTE_SHIFT))); // R6
  AST_INST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !iTake |=> $stable(capITag) && $stable(capIForm));                        // R7
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |=> (capVa == '0) && (capStat == '0) && (capDForm == '0)
              && (capITag == '0) && (capIForm == '0));                        // R8
  AST_READ_SPARE: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr > 3'd4) |-> rdData == '0);                                        // R9

endmodule

bind xlat_fault_capture xfc_checker #(
  .ADDR_W    (ADDR_W),
  .PAGE_SHIFT(PAGE_SHIFT),
  .PTE_SHIFT (PTE_SHIFT)
) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .dFaultValid  (dFaultValid),
  .dFaultVaddr  (dFaultVaddr),
  .dFaultOpcode (dFaultOpcode),
  .dFaultRa     (dFaultRa),
  .dFaultSpec   (dFaultSpec),
  .dFaultPteLoad(dFaultPteLoad),
  .dFaultNoFault(dFaultNoFault),
  .iFaultValid  (iFaultValid),
  .iFaultPc     (iFaultPc),
  .iFaultSpec   (iFaultSpec),
  .dPtBase      (dPtBase),
  .iPtBase      (iPtBase),
  .rdAddr       (rdAddr),
  .rdData       (rdData),
  .capVa        (capVa),
  .capStat      (capStat),
  .capDForm     (capDForm),
  .capITag      (capITag),
  .capIForm     (capIForm)
);

// File: tb/xlat_fault_capture_test.sv
module xlat_fault_capture_test;

  localparam int AW = 64;
  localparam int NV = 10;

  typedef struct packed {
    logic          dv;
    logic          dSpec;
    logic          dPte;
    logic          dNf;
    logic          iv;
    logic          iSpec;
    logic [AW-1:0] addr;
    logic [AW-1:0] pc;
    logic [5:0]    opc;
    logic [4:0]    ra;
    logic [AW-1:0] dBase;
    logic [AW-1:0] iBase;
  } vec_t;

  // dv dSpec dPte dNf iv iSpec addr pc opc ra dBase iBase
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 64'h0000_0012_3456_7ABC, 64'h0, 6'h2C, 5'h13, 64'hFFFF_FE00_0000_0000, 64'h0},
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 64'h0, 64'h0000_0000_0020_4000, 6'h00, 5'h00, 64'h0, 64'hFFFF_FC00_0000_0000},
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 64'hDEAD_0000_0000_2000, 64'h0, 6'h3F, 5'h1F, 64'h1111_0000_0000_0000, 64'h0},
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 64'hBEEF_0000_0000_4000, 64'h0, 6'h15, 5'h0A, 64'h2222_0000_0000_0000, 64'h0},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 64'hCAFE_0000_0000_6000, 64'h0, 6'h2A, 5'h15, 64'h3333_0000_0000_0000, 64'h0},
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 64'h0, 64'h7777_0000_0000_8000, 6'h00, 5'h00, 64'h0, 64'h4444_0000_0000_0000},
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_1FFF, 6'h3F, 5'h1F, 64'h0, 64'h0000_0000_0000_0007},
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0, 64'h5555_0000_0000_0000, 64'h0000_0ABC_DE00_0000, 6'h01, 5'h01, 64'h6666_0000_0000_0000, 64'h8000_0000_0000_0000},
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 64'h0000_0000_0000_E000, 64'h9999_0000_0000_0000, 6'h21, 5'h11, 64'h0000_0000_0000_0005, 64'hAAAA_0000_0000_0000},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 64'h0123_4567_89AB_CDEF, 64'h0, 6'h10, 5'h08, 64'h0000_0000_0000_0000, 64'h0}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          dFaultValid = 1'b0;
  logic [AW-1:0] dFaultVaddr = '0;
  logic [5:0]    dFaultOpcode = '0;
  logic [4:0]    dFaultRa = '0;
  logic          dFaultSpec = 1'b0;
  logic          dFaultPteLoad = 1'b0;
  logic          dFaultNoFault = 1'b0;
  logic          iFaultValid = 1'b0;
  logic [AW-1:0] iFaultPc = '0;
  logic          iFaultSpec = 1'b0;
  logic [AW-1:0] dPtBase = '0;
  logic [AW-1:0] iPtBase = '0;
  logic [2:0]    rdAddr = '0;
  logic [AW-1:0] rdData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [AW-1:0] mVa, mStat, mDForm, mITag, mIForm;

  xlat_fault_capture uut (
    .clk(clk), .rstN(rstN),
    .dFaultValid(dFaultValid), .dFaultVaddr(dFaultVaddr), .dFaultOpcode(dFaultOpcode),
    .dFaultRa(dFaultRa), .dFaultSpec(dFaultSpec), .dFaultPteLoad(dFaultPteLoad),
    .dFaultNoFault(dFaultNoFault), .iFaultValid(iFaultValid), .iFaultPc(iFaultPc),
    .iFaultSpec(iFaultSpec), .dPtBase(dPtBase), .iPtBase(iPtBase),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  always #10 clk = ~clk;

  function automatic logic [AW-1:0] fmtExp(input logic [AW-1:0] b, input logic [AW-1:0] a);
    return b | ((a >> 13) << 3);
  endfunction

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readAt(input logic [2:0] a, output logic [AW-1:0] v);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic checkAll(input string tag);
    logic [AW-1:0] v;
    readAt(3'd0, v); check({tag, " R2 va"}, v, mVa);
    readAt(3'd1, v); check({tag, " R3 status"}, v, mStat);
    readAt(3'd2, v); check({tag, " R4 dform"}, v, mDForm);
    readAt(3'd3, v); check({tag, " R5 itag"}, v, mITag);
    readAt(3'd4, v); check({tag, " R6 iform"}, v, mIForm);
  endtask

  task automatic checkSpare(input string tag);
    logic [AW-1:0] v;
    for (int a = 5; a < 8; a++) begin
      readAt(3'(a), v);
      check({tag, " R9 spare"}, v, '0);
    end
  endtask

  task automatic clearModel();
    mVa = '0; mStat = '0; mDForm = '0; mITag = '0; mIForm = '0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clearModel();
    // R8: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkAll("reset R8");
    checkSpare("reset");
    rstN = 1'b1;

    // Vector table: R1 R7 R10 qualification across both sides
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      dFaultValid   = VEC[i].dv;
      dFaultSpec    = VEC[i].dSpec;
      dFaultPteLoad = VEC[i].dPte;
      dFaultNoFault = VEC[i].dNf;
      dFaultVaddr   = VEC[i].addr;
      dFaultOpcode  = VEC[i].opc;
      dFaultRa      = VEC[i].ra;
      dPtBase       = VEC[i].dBase;
      iFaultValid   = VEC[i].iv;
      iFaultSpec    = VEC[i].iSpec;
      iFaultPc      = VEC[i].pc;
      iPtBase       = VEC[i].iBase;
      if (VEC[i].dv && !VEC[i].dSpec && !VEC[i].dPte && !VEC[i].dNf) begin
        mVa    = VEC[i].addr;
        mStat  = (AW'(VEC[i].opc) << 11) | (AW'(VEC[i].ra) << 6);
        mDForm = fmtExp(VEC[i].dBase, VEC[i].addr);
      end
      if (VEC[i].iv && !VEC[i].iSpec) begin
        mITag  = VEC[i].pc;
        mIForm = fmtExp(VEC[i].iBase, VEC[i].pc);
      end
      @(negedge clk);
      dFaultValid = 1'b0;
      iFaultValid = 1'b0;
      checkAll($sformatf("vec%0d R1 R7 R10", i));
    end

    // R7: base changes with no fault leave formatted values alone
    @(negedge clk);
    dPtBase = 64'hFFFF_FFFF_FFFF_FFFF;
    iPtBase = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (2) @(negedge clk);
    checkAll("idle-base R7");
    checkSpare("loaded");

    // R1: all three data qualifiers together still block
    dFaultValid = 1'b1; dFaultSpec = 1'b1; dFaultPteLoad = 1'b1; dFaultNoFault = 1'b1;
    dFaultVaddr = 64'h1;
    @(negedge clk);
    dFaultValid = 1'b0; dFaultSpec = 1'b0; dFaultPteLoad = 1'b0; dFaultNoFault = 1'b0;
    checkAll("allflags R1");

    // R8: reset in mid-run clears loaded registers
    rstN = 1'b0;
    clearModel();
    @(negedge clk);
    checkAll("midreset R8");
    rstN = 1'b1;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule